// File: doc/BRIEF.md
# System Control Coprocessor Register Bank

This block sits in a coprocessor slot next to a CPU core. The core reaches it only through two register-transfer operations: a move-to-coprocessor write (`wr_en_i`) and a move-from-coprocessor read (`rd_en_i`). Bits 19:16 of the presented instruction word select a register. Only the low three bits of that field count, so the bank has eight slots.

Slot 0 returns a fixed identification word. Slot 1 is the only writable register. Bits 7:4 of slot 1 drive four core configuration lines: program-space width, data-space width, abort timing and byte order. At reset those four bits take their values from strap inputs. A write that changes any of the four bits raises a one-cycle mode-change pulse, which tells the core to re-evaluate its operating mode.

Both strobes are plain control pins. The block accepts every strobe in the cycle it is presented and never applies back-pressure. Read data is combinational in the strobe cycle. A write takes effect at the next clock edge.

Top module: `sysctl_cp_regs`

## Requirements
- R1: While `rst_n` is low, at a clock edge the four configuration outputs load from the strap inputs and `mode_chg_o` clears to 0.
- R2: The slot index is instruction bits 18:16. Bit 19 is ignored, so index field value 9 reaches slot 1.
- R3: A read of slot 0 returns 0x41440110. A write to slot 0 changes no output and raises no pulse.
- R4: A read of slot 1 returns prog32 in bit 4, data32 in bit 5, late abort in bit 6 and big-endian in bit 7. All other bits read 0.
- R5: After the clock edge that samples a slot-1 write, prog32/data32/late-abort/big-endian equal write-data bits 4/5/6/7.
- R6: `mode_chg_o` is high for exactly the one cycle after the edge that samples a slot-1 write which changes at least one configuration bit.
- R7: A write to slot 1 whose bits 7:4 equal the current configuration leaves `mode_chg_o` low. Changes in write-data bits 3:0 and 31:8 have no effect.
- R8: Slots 2 to 7 read 0. Writes to them change no output and raise no pulse.
- R9: `rdata_o` is 0 whenever `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 32 | Instruction word; bits 18:16 select the slot |
| wdata_i | input | 32 | Write data for a register write |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| strap_prog32_i | input | 1 | Reset value of program-space width |
| strap_data32_i | input | 1 | Reset value of data-space width |
| strap_late_abt_i | input | 1 | Reset value of abort timing |
| strap_big_end_i | input | 1 | Reset value of byte order |
| rdata_o | output | 32 | Read data |
| prog32_o | output | 1 | 32-bit program space selected |
| data32_o | output | 1 | 32-bit data space selected |
| late_abt_o | output | 1 | Late abort timing selected |
| big_end_o | output | 1 | Big-endian operation selected |
| mode_chg_o | output | 1 | One-cycle pulse on a configuration change |

## Verification
The bench builds the block with its default parameters: a 32-bit word, the index field starting at bit 16, a 3-bit slot number, and the configuration field starting at bit 4. These values make every one of the eight slots reachable. They also let an index value above 7 show the aliasing. The bench writes configuration patterns that flip one bit, flip all bits, or flip none, and checks the pulse in the cycle after each write and in the cycle after that.

// File: rtl/scb_pkg.sv
package scb_pkg;
  // Four configuration bits, packed so bit 0 is program width and bit 3 is byte order
  typedef struct packed {
    logic big_end;
    logic late_abt;
    logic data32;
    logic prog32;
  } cfg_t;

  localparam int CFG_BITS = $bits(cfg_t);
  localparam logic [31:0] ID_WORD = 32'h4144_0110;
endpackage

// File: rtl/scb_slot_decode.sv
module scb_slot_decode #(
  parameter int DATA_W = 32,
  parameter int IDX_LO = 16,
  parameter int SLOT_W = 3
) (
  input  logic [DATA_W-1:0]      instr,
  output logic [SLOT_W-1:0]      slot,
  output logic [(1<<SLOT_W)-1:0] sel
);
  localparam int N_SLOTS = 1 << SLOT_W;

  // The fourth index bit is dropped: the field is masked down to SLOT_W bits
  assign slot = instr[IDX_LO +: SLOT_W];

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_sel
    assign sel[g] = (slot == SLOT_W'(g));
  end

  always_comb begin
    assert ($onehot0(sel)) else $error("AST_SEL_ONEHOT"); // R2
  end

  logic unused_instr;
  assign unused_instr = ^{instr[DATA_W-1:IDX_LO+SLOT_W], instr[IDX_LO-1:0]};
endmodule

// File: rtl/scb_ctrl_reg.sv
module scb_ctrl_reg
  import scb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  cfg_t wr_cfg,
  input  cfg_t strap_cfg,
  output cfg_t cfg,
  output logic mode_chg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= strap_cfg;
      mode_chg <= 1'b0;
    end else begin
      mode_chg <= wr_hit && (wr_cfg != cfg);
      if (wr_hit) cfg <= wr_cfg;
    end
  end

  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |-> $past(wr_hit)) else $error("AST_PULSE_NEEDS_WRITE"); // R6
  AST_PULSE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |-> (cfg != $past(cfg))) else $error("AST_PULSE_MEANS_CHANGE"); // R6
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_hit) |-> $stable(cfg)) else $error("AST_HOLD_NO_WRITE"); // R8
  AST_NO_PULSE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_hit) |-> !mode_chg) else $error("AST_NO_PULSE_NO_WRITE"); // R7
endmodule

// File: rtl/scb_read_mux.sv
module scb_read_mux
  import scb_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          SLOT_W  = 3,
  parameter int          CFG_LSB = 4,
  parameter logic [31:0] ID_VAL  = ID_WORD
) (
  input  logic                   rd_en,
  input  logic [(1<<SLOT_W)-1:0] sel,
  input  cfg_t                   cfg,
  output logic [DATA_W-1:0]      rdata
);
  localparam int CFG_MSB = CFG_LSB + CFG_BITS - 1;

  logic [DATA_W-1:0] ctrl_word;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CFG_MSB:CFG_LSB] = cfg;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (sel[0])      rdata = DATA_W'(ID_VAL);
      else if (sel[1]) rdata = ctrl_word;
    end
  end

  always_comb begin
    if (!rd_en) assert (rdata == '0) else $error("AST_IDLE_READ_ZERO"); // R9
  end

  logic unused_sel;
  assign unused_sel = ^sel[(1<<SLOT_W)-1:2];
endmodule

// File: rtl/sysctl_cp_regs.sv
module sysctl_cp_regs
  import scb_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          IDX_LO  = 16,
  parameter int          SLOT_W  = 3,
  parameter int          CFG_LSB = 4,
  parameter logic [31:0] ID_VAL  = ID_WORD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] instr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic              strap_prog32_i,
  input  logic              strap_data32_i,
  input  logic              strap_late_abt_i,
  input  logic              strap_big_end_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              prog32_o,
  output logic              data32_o,
  output logic              late_abt_o,
  output logic              big_end_o,
  output logic              mode_chg_o
);
  localparam int N_SLOTS = 1 << SLOT_W;
  localparam int CFG_MSB = CFG_LSB + CFG_BITS - 1;

  logic [SLOT_W-1:0]  slot;
  logic [N_SLOTS-1:0] sel;
  cfg_t               cfg, strap_cfg, wr_cfg;
  logic               wr_hit;

  scb_slot_decode #(.DATA_W(DATA_W), .IDX_LO(IDX_LO), .SLOT_W(SLOT_W)) u_dec (
    .instr (instr_i),
    .slot  (slot),
    .sel   (sel)
  );

  assign strap_cfg = '{big_end: strap_big_end_i, late_abt: strap_late_abt_i,
                       data32: strap_data32_i, prog32: strap_prog32_i};
  assign wr_cfg    = wdata_i[CFG_MSB:CFG_LSB];
  assign wr_hit    = wr_en_i && sel[1];

  scb_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit),
    .wr_cfg    (wr_cfg),
    .strap_cfg (strap_cfg),
    .cfg       (cfg),
    .mode_chg  (mode_chg_o)
  );

  scb_read_mux #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .CFG_LSB(CFG_LSB), .ID_VAL(ID_VAL)) u_rd (
    .rd_en (rd_en_i),
    .sel   (sel),
    .cfg   (cfg),
    .rdata (rdata_o)
  );

  assign prog32_o   = cfg.prog32;
  assign data32_o   = cfg.data32;
  assign late_abt_o = cfg.late_abt;
  assign big_end_o  = cfg.big_end;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:CFG_MSB+1], wdata_i[CFG_LSB-1:0], slot};

  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && instr_i[IDX_LO +: SLOT_W] == '0) |-> (rdata_o == DATA_W'(ID_VAL)))
    else $error("AST_ID_READ"); // R3
  AST_RSVD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o[CFG_LSB-1:0] == '0) || (rdata_o == DATA_W'(ID_VAL)))
    else $error("AST_RSVD_BITS_ZERO"); // R4
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && instr_i[IDX_LO +: SLOT_W] == SLOT_W'(1)) |=>
      ({big_end_o, late_abt_o, data32_o, prog32_o} == $past(wdata_i[CFG_MSB:CFG_LSB])))
    else $error("AST_WRITE_LANDS"); // R5
endmodule

// File: tb/sysctl_cp_regs_bench.sv
module sysctl_cp_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_i = '0, wdata_i = '0;
  logic        rd_en_i = 1'b0, wr_en_i = 1'b0;
  logic        sp = 1'b1, sd = 1'b1, sl = 1'b0, sb = 1'b0;
  logic [31:0] rdata_o;
  logic        prog32_o, data32_o, late_abt_o, big_end_o, mode_chg_o;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sysctl_cp_regs u_sysctl_cp_regs (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .wdata_i(wdata_i),
    .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
    .strap_prog32_i(sp), .strap_data32_i(sd), .strap_late_abt_i(sl), .strap_big_end_i(sb),
    .rdata_o(rdata_o), .prog32_o(prog32_o), .data32_o(data32_o),
    .late_abt_o(late_abt_o), .big_end_o(big_end_o), .mode_chg_o(mode_chg_o)
  );

  function automatic logic [31:0] mk(input logic [3:0] idx);
    return 32'hEE00_0F10 | (32'(idx) << 16);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {big_end_o, late_abt_o, data32_o, prog32_o};
  endfunction

  task automatic do_read(input logic [3:0] idx, output logic [31:0] v);
    @(negedge clk);
    instr_i = mk(idx); rd_en_i = 1'b1;
    #1 v = rdata_o;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  // Drive one write; returns pulse in the cycle after and the cycle after that
  task automatic do_write(input logic [3:0] idx, input logic [31:0] d,
                          output logic p1, output logic p2);
    @(negedge clk);
    instr_i = mk(idx); wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; wdata_i = '0;
    p1 = mode_chg_o;
    @(negedge clk);
    p2 = mode_chg_o;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 cfg from straps", 32'(outs()), 32'h3);
    chk("R1 pulse clear", 32'(mode_chg_o), 32'h0);
  endtask

  task automatic t_id();
    logic [31:0] v; logic p1, p2;
    do_read(4'd0, v);
    chk("R3 id read", v, 32'h4144_0110);
    do_write(4'd0, 32'hFFFF_FFFF, p1, p2);
    chk("R3 id write no cfg effect", 32'(outs()), 32'h3);
    chk("R3 id write no pulse", 32'({p1, p2}), 32'h0);
    do_read(4'd0, v);
    chk("R3 id after write", v, 32'h4144_0110);
  endtask

  task automatic t_ctrl_read();
    logic [31:0] v;
    do_read(4'd1, v);
    chk("R4 ctrl read", v, 32'h0000_0030);
  endtask

  task automatic t_write_change();
    logic [31:0] v; logic p1, p2;
    do_write(4'd1, 32'h0000_00C0, p1, p2);
    chk("R5 all flip outs", 32'(outs()), 32'hC);
    chk("R6 pulse after write", 32'(p1), 32'h1);
    chk("R6 pulse single cycle", 32'(p2), 32'h0);
    do_read(4'd1, v);
    chk("R4 ctrl read back", v, 32'h0000_00C0);
    do_write(4'd1, 32'h0000_00D0, p1, p2);
    chk("R5 one bit flip", 32'(outs()), 32'hD);
    chk("R6 one bit pulse", 32'({p1, p2}), 32'h2);
  endtask

  task automatic t_write_same();
    logic [31:0] v; logic p1, p2;
    do_write(4'd1, 32'h1234_56DF, p1, p2);
    chk("R7 same bits no pulse", 32'({p1, p2}), 32'h0);
    chk("R7 same bits outs", 32'(outs()), 32'hD);
    do_read(4'd1, v);
    chk("R7 junk bits ignored", v, 32'h0000_00D0);
  endtask

  task automatic t_alias();
    logic [31:0] v; logic p1, p2;
    do_read(4'd9, v);
    chk("R2 alias read", v, 32'h0000_00D0);
    do_read(4'd8, v);
    chk("R2 alias id", v, 32'h4144_0110);
    do_write(4'd9, 32'h0000_0020, p1, p2);
    chk("R2 alias write", 32'(outs()), 32'h2);
    chk("R2 alias pulse", 32'(p1), 32'h1);
  endtask

  task automatic t_unused();
    logic [31:0] v; logic p1, p2;
    for (int i = 2; i < 8; i++) begin
      do_write(4'(i), 32'hFFFF_FFFF, p1, p2);
      chk("R8 unused write no pulse", 32'({p1, p2}), 32'h0);
      chk("R8 unused write outs", 32'(outs()), 32'h2);
      do_read(4'(i), v);
      chk("R8 unused read zero", v, 32'h0);
    end
  endtask

  task automatic t_idle();
    @(negedge clk);
    rd_en_i = 1'b0; instr_i = mk(4'd0);
    #1 chk("R9 idle id slot", rdata_o, 32'h0);
    instr_i = mk(4'd1);
    #1 chk("R9 idle ctrl slot", rdata_o, 32'h0);
  endtask

  initial begin
    t_reset();
    t_id();
    t_ctrl_read();
    t_write_change();
    t_write_same();
    t_alias();
    t_unused();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule